// File: doc/BRIEF.md
# Feistel Block Cipher with an AES Round Function

This block encrypts and decrypts 256-bit blocks with a ten-round Feistel network. The block is split into a left half (the upper 128 bits) and a right half (the lower 128 bits). In each round the right half passes through one complete AES round keyed by a 128-bit round key. The result is XORed into the left half, and then the two halves trade places. The round keys come from the standard AES-128 key schedule applied to a 128-bit cipher key. All ten keys are computed once, one per clock, and held in registers.

A key is presented with `key_valid`, and `key_ready` rises once all ten round keys are in place. After that, each `start` pulse launches one operation on `data_in`. The `decrypt` bit sampled with `start` selects the direction, and decryption uses the same datapath with the keys applied last-to-first. The core computes one Feistel round per clock and presents the result on `data_out` together with a one-cycle `done` pulse.

Top module: `feistel_aes_cipher`

## Requirements
- R1: While and after reset, `done`, `key_ready` and `data_out` are all zero until a key load and an operation complete.
- R2: A key load is accepted on a clock edge where `key_valid` is high and no operation is running. `key_ready` is low after that edge and rises exactly 10 clock edges later.
- R3: Encryption takes `data_in[255:128]` as L0 and `data_in[127:0]` as R0. Each round i (1..10) sets L_i = R_{i-1} and R_i = L_{i-1} XOR F(R_{i-1}, K_i), and the output is {R10, L10}. F is AES SubBytes, then ShiftRows, then MixColumns, then XOR with K_i, where K_i is the i-th round key of the AES-128 expansion of the loaded key. Within a 128-bit half, byte 0 is bits [127:120] and column c holds bytes 4c..4c+3.
- R4: With `decrypt` high, the same network runs with K10 first and K1 last, so decrypting a ciphertext returns the original plaintext.
- R5: `done` is high for exactly one cycle, after the 10th clock edge following the edge that accepted `start`. `data_out` takes the result on that same edge and keeps it until the next `done`.
- R6: A `start` that arrives while an operation is running is ignored. The running result is unchanged and no extra `done` follows.
- R7: A `start` is ignored while `key_ready` is low, and also in any cycle where `key_valid` is high.
- R8: A `key_valid` pulse during a running operation is ignored. The operation and later ones use the keys already loaded, and `key_ready` stays high.
- R9: Flipping any single plaintext bit changes the ciphertext.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| key_valid | input | 1 | Strobe to load `key_in` and expand it |
| key_in | input | 128 | Cipher key |
| key_ready | output | 1 | All round keys are expanded and held |
| start | input | 1 | Strobe to launch one operation |
| decrypt | input | 1 | Direction sampled with `start`: 1 = decrypt |
| data_in | input | 256 | Input block sampled with `start` |
| data_out | output | 256 | Result block, valid from `done` onward |
| done | output | 1 | One-cycle pulse when `data_out` is updated |

## Verification
The bench checks four groups of corner cases.

- **Timing edges.** `done` must appear on exactly the tenth edge after start, not the ninth. A core that adds a load cycle or lets the round counter drift would pulse late or early. `key_ready` is checked the same way, on the ninth and tenth edges after a key load.
- **Key order and half order.** Ciphertext from all-zero, all-one and mixed blocks is compared against a separate model, and each result is decrypted back. Any error in key order, half order or the final swap breaks one of these comparisons.
- **Gated strobes.** The bench issues a start during an operation, a start before the keys are ready, a start in the same cycle as a key load, and a key load during an operation. A design that failed to gate these would restart the operation, produce a stray `done`, or switch to a corrupted key set.
- **Diffusion.** Flips of a single plaintext bit must change the ciphertext.

// File: rtl/fac_pkg.sv
package fac_pkg;

   localparam int AES_W      = 128;
   localparam int MAX_ROUNDS = 10;

   // GF(2^8) multiply: carry-less product followed by reduction by x^8+x^4+x^3+x+1
   function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
      logic [14:0] p;
      p = '0;
      for (int i = 0; i < 8; i++)
         if (b[i]) p = p ^ (15'(a) << i);
      for (int i = 14; i >= 8; i--)
         if (p[i]) p = p ^ (15'(9'h11B) << (i - 8));
      return p[7:0];
   endfunction

   // Substitution byte: inverse as x^254, then the affine map
   function automatic logic [7:0] sbox_calc(input logic [7:0] x);
      logic [7:0] inv;
      logic [7:0] expo;
      expo = 8'd254;
      inv  = 8'h01;
      for (int i = 7; i >= 0; i--) begin
         inv = gf_mul(inv, inv);
         if (expo[i]) inv = gf_mul(inv, x);
      end
      return inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]} ^
             {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
   endfunction

   // Column mix of one 32-bit column, top byte is row 0
   function automatic logic [31:0] mix_col(input logic [31:0] c);
      logic [7:0] a0, a1, a2, a3;
      a0 = c[31:24];
      a1 = c[23:16];
      a2 = c[15:8];
      a3 = c[7:0];
      return {gf_mul(a0, 8'd2) ^ gf_mul(a1, 8'd3) ^ a2 ^ a3,
              a0 ^ gf_mul(a1, 8'd2) ^ gf_mul(a2, 8'd3) ^ a3,
              a0 ^ a1 ^ gf_mul(a2, 8'd2) ^ gf_mul(a3, 8'd3),
              gf_mul(a0, 8'd3) ^ a1 ^ a2 ^ gf_mul(a3, 8'd2)};
   endfunction

endpackage

// File: rtl/fac_sbox.sv
module fac_sbox (
   input  logic [7:0] byte_i,
   output logic [7:0] byte_o
);
   assign byte_o = fac_pkg::sbox_calc(byte_i);
endmodule

// File: rtl/fac_aes_round.sv
module fac_aes_round #(
   parameter int W = 128
) (
   input  logic [W-1:0] state_i,
   input  logic [W-1:0] rkey_i,
   output logic [W-1:0] state_o
);
   localparam int NBYTES = W / 8;
   localparam int NCOLS  = NBYTES / 4;

   if (W != fac_pkg::AES_W) begin : g_bad_width
      $error("fac_aes_round: W must be 128");
   end

   logic [7:0]   sub_b [NBYTES];
   logic [7:0]   shf_b [NBYTES];
   logic [W-1:0] mixed;

   for (genvar n = 0; n < NBYTES; n++) begin : g_sub
      fac_sbox u_sbox (
         .byte_i (state_i[W-1-8*n -: 8]),
         .byte_o (sub_b[n])
      );
   end

   // row r of column c takes row r of column (c+r) mod 4
   for (genvar c = 0; c < NCOLS; c++) begin : g_col
      for (genvar r = 0; r < 4; r++) begin : g_row
         assign shf_b[4*c+r] = sub_b[4*((c+r)%NCOLS)+r];
      end
      assign mixed[W-1-32*c -: 32] =
         fac_pkg::mix_col({shf_b[4*c], shf_b[4*c+1], shf_b[4*c+2], shf_b[4*c+3]});
   end

   assign state_o = mixed ^ rkey_i;
endmodule

// File: rtl/fac_key_expand.sv
module fac_key_expand #(
   parameter int KEY_W      = 128,
   parameter int NUM_ROUNDS = 10
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             load_i,
   input  logic [KEY_W-1:0]                 key_i,
   output logic [NUM_ROUNDS-1:0][KEY_W-1:0] rk_o,
   output logic                             ready_o
);
   localparam int CNT_W = $clog2(NUM_ROUNDS + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_ROUNDS - 1);

   if (KEY_W != fac_pkg::AES_W) begin : g_bad_key
      $error("fac_key_expand: KEY_W must be 128");
   end

   logic [KEY_W-1:0]                 w_q;
   logic [7:0]                       rcon_q;
   logic [CNT_W-1:0]                 kcnt_q;
   logic                             run_q;
   logic                             ready_q;
   logic [NUM_ROUNDS-1:0][KEY_W-1:0] rk_q;

   logic [31:0]      rot_w;
   logic [31:0]      sub_w;
   logic [31:0]      tmp_w;
   logic [KEY_W-1:0] next_w;

   assign rot_w = {w_q[23:0], w_q[31:24]};

   for (genvar j = 0; j < 4; j++) begin : g_subword
      fac_sbox u_sbox (
         .byte_i (rot_w[31-8*j -: 8]),
         .byte_o (sub_w[31-8*j -: 8])
      );
   end

   assign tmp_w = sub_w ^ {rcon_q, 24'h0};

   always_comb begin
      next_w[127:96] = w_q[127:96] ^ tmp_w;
      next_w[95:64]  = w_q[95:64]  ^ next_w[127:96];
      next_w[63:32]  = w_q[63:32]  ^ next_w[95:64];
      next_w[31:0]   = w_q[31:0]   ^ next_w[63:32];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         w_q     <= '0;
         rcon_q  <= '0;
         kcnt_q  <= '0;
         run_q   <= 1'b0;
         ready_q <= 1'b0;
         rk_q    <= '0;
      end else if (load_i) begin
         w_q     <= key_i;
         rcon_q  <= 8'h01;
         kcnt_q  <= '0;
         run_q   <= 1'b1;
         ready_q <= 1'b0;
      end else if (run_q) begin
         rk_q[kcnt_q] <= next_w;
         w_q          <= next_w;
         rcon_q       <= fac_pkg::gf_mul(rcon_q, 8'h02);
         kcnt_q       <= kcnt_q + 1'b1;
         if (kcnt_q == LAST) begin
            run_q   <= 1'b0;
            ready_q <= 1'b1;
         end
      end
   end

   assign rk_o    = rk_q;
   assign ready_o = ready_q;

   AST_LOAD_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> !ready_o); // R2
   AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (ready_o && !load_i) |=> ready_o); // R2
   AST_NO_READY_WHILE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |-> !ready_o); // R2
endmodule

// File: rtl/feistel_aes_cipher.sv
module feistel_aes_cipher #(
   parameter int BLOCK_W    = 256,
   parameter int KEY_W      = 128,
   parameter int NUM_ROUNDS = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               key_valid,
   input  logic [KEY_W-1:0]   key_in,
   output logic               key_ready,
   input  logic               start,
   input  logic               decrypt,
   input  logic [BLOCK_W-1:0] data_in,
   output logic [BLOCK_W-1:0] data_out,
   output logic               done
);
   localparam int HALF_W = BLOCK_W / 2;
   localparam int CNT_W  = $clog2(NUM_ROUNDS + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_ROUNDS - 1);

   if (KEY_W != fac_pkg::AES_W) begin : g_bad_key
      $error("feistel_aes_cipher: KEY_W must be 128");
   end
   if (BLOCK_W != 2 * KEY_W) begin : g_bad_block
      $error("feistel_aes_cipher: BLOCK_W must be twice KEY_W");
   end
   if (NUM_ROUNDS < 2 || NUM_ROUNDS > fac_pkg::MAX_ROUNDS) begin : g_bad_rounds
      $error("feistel_aes_cipher: NUM_ROUNDS out of range");
   end

   logic [NUM_ROUNDS-1:0][KEY_W-1:0] rk;
   logic                             busy_q;
   logic                             dec_q;
   logic [CNT_W-1:0]                 cnt_q;
   logic [HALF_W-1:0]                lh_q, rh_q;
   logic [BLOCK_W-1:0]               out_q;
   logic                             done_q;

   logic              key_load;
   logic              go;
   logic [CNT_W-1:0]  key_idx;
   logic [HALF_W-1:0] f_out;
   logic [HALF_W-1:0] new_l, new_r;

   assign key_load = key_valid && !busy_q;
   assign go       = start && !busy_q && key_ready && !key_valid;

   fac_key_expand #(
      .KEY_W      (KEY_W),
      .NUM_ROUNDS (NUM_ROUNDS)
   ) u_keys (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (key_load),
      .key_i   (key_in),
      .rk_o    (rk),
      .ready_o (key_ready)
   );

   assign key_idx = dec_q ? (LAST - cnt_q) : cnt_q;

   fac_aes_round #(.W(HALF_W)) u_f (
      .state_i (rh_q),
      .rkey_i  (rk[key_idx]),
      .state_o (f_out)
   );

   assign new_l = rh_q;
   assign new_r = lh_q ^ f_out;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         dec_q  <= 1'b0;
         cnt_q  <= '0;
         lh_q   <= '0;
         rh_q   <= '0;
         out_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (go) begin
            busy_q <= 1'b1;
            dec_q  <= decrypt;
            cnt_q  <= '0;
            lh_q   <= data_in[BLOCK_W-1:HALF_W];
            rh_q   <= data_in[HALF_W-1:0];
         end else if (busy_q) begin
            lh_q  <= new_l;
            rh_q  <= new_r;
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
               out_q  <= {new_r, new_l};
            end
         end
      end
   end

   assign data_out = out_q;
   assign done     = done_q;

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R5
   AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(data_out)); // R5
   AST_ROUND_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && cnt_q != LAST) |=> (busy_q && cnt_q == CNT_W'($past(cnt_q) + 1'b1))); // R6
   AST_START_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> $past(key_ready)); // R7
   AST_KEYS_KEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> key_ready); // R8
endmodule

// File: tb/feistel_aes_cipher_tb_top.sv
module feistel_aes_cipher_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 4;
   // each entry: {key[127:0], plaintext[255:0]}
   localparam logic [383:0] VEC [NVEC] = '{
      {128'h0, 256'h0},
      {128'h000102030405060708090a0b0c0d0e0f,
       256'h00112233445566778899aabbccddeeffffeeddccbbaa99887766554433221100},
      {{32{4'hf}}, {64{4'hf}}},
      {128'h2b7e151628aed2a6abf7158809cf4f3c,
       256'h0123456789abcdeffedcba9876543210a5a5a5a5a5a5a5a55a5a5a5a5a5a5a5a}
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         key_valid = 1'b0;
   logic [127:0] key_in = '0;
   logic         key_ready;
   logic         start = 1'b0;
   logic         decrypt = 1'b0;
   logic [255:0] data_in = '0;
   logic [255:0] data_out;
   logic         done;

   int nchk = 0;
   int nfail = 0;

   logic [7:0]   sbt [256];
   logic [127:0] mk  [10];

   always #(CLK_PERIOD/2) clk = ~clk;

   feistel_aes_cipher dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .key_valid (key_valid),
      .key_in    (key_in),
      .key_ready (key_ready),
      .start     (start),
      .decrypt   (decrypt),
      .data_in   (data_in),
      .data_out  (data_out),
      .done      (done)
   );

   // ---------------- reference model ----------------
   function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
      logic [7:0] r;
      r = 8'h00;
      for (int i = 0; i < 8; i++) begin
         if (b[i]) r = r ^ a;
         a = a[7] ? ({a[6:0], 1'b0} ^ 8'h1b) : {a[6:0], 1'b0};
      end
      return r;
   endfunction

   task automatic m_build_sbox();
      for (int x = 0; x < 256; x++) begin
         logic [7:0] inv, s;
         inv = 8'h00;
         for (int y = 1; y < 256; y++)
            if (m_mul(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
         for (int i = 0; i < 8; i++)
            s[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^
                   inv[(i+7)%8] ^ ((8'h63 >> i) & 8'h01) != 0;
         sbt[x] = s;
      end
   endtask

   function automatic logic [127:0] m_round(input logic [127:0] st, input logic [127:0] k);
      logic [7:0] b [16];
      logic [7:0] t [16];
      logic [127:0] o;
      for (int n = 0; n < 16; n++) b[n] = sbt[st[127-8*n -: 8]];
      for (int c = 0; c < 4; c++)
         for (int r = 0; r < 4; r++) t[4*c+r] = b[4*((c+r)%4)+r];
      for (int c = 0; c < 4; c++) begin
         o[127-32*c -: 8] = m_mul(t[4*c],8'd2) ^ m_mul(t[4*c+1],8'd3) ^ t[4*c+2] ^ t[4*c+3];
         o[119-32*c -: 8] = t[4*c] ^ m_mul(t[4*c+1],8'd2) ^ m_mul(t[4*c+2],8'd3) ^ t[4*c+3];
         o[111-32*c -: 8] = t[4*c] ^ t[4*c+1] ^ m_mul(t[4*c+2],8'd2) ^ m_mul(t[4*c+3],8'd3);
         o[103-32*c -: 8] = m_mul(t[4*c],8'd3) ^ t[4*c+1] ^ t[4*c+2] ^ m_mul(t[4*c+3],8'd2);
      end
      return o ^ k;
   endfunction

   task automatic m_expand(input logic [127:0] key);
      logic [31:0] w [44];
      logic [31:0] tw;
      logic [7:0]  rc;
      rc = 8'h01;
      for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
      for (int i = 4; i < 44; i++) begin
         tw = w[i-1];
         if (i % 4 == 0) begin
            tw = {sbt[tw[23:16]], sbt[tw[15:8]], sbt[tw[7:0]], sbt[tw[31:24]]} ^ {rc, 24'h0};
            rc = m_mul(rc, 8'h02);
         end
         w[i] = w[i-4] ^ tw;
      end
      for (int r = 0; r < 10; r++) mk[r] = {w[4*r+4], w[4*r+5], w[4*r+6], w[4*r+7]};
   endtask

   function automatic logic [255:0] m_crypt(input logic [255:0] d, input bit dec);
      logic [127:0] l, r, t;
      l = d[255:128];
      r = d[127:0];
      for (int i = 0; i < 10; i++) begin
         t = l ^ m_round(r, dec ? mk[9-i] : mk[i]);
         l = r;
         r = t;
      end
      return {r, l};
   endfunction

   // ---------------- checking helpers ----------------
   task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic load_key(input logic [127:0] k);
      @(negedge clk);
      key_valid = 1'b1;
      key_in    = k;
      @(negedge clk);
      key_valid = 1'b0;
      for (int i = 1; i <= 10; i++) begin
         @(negedge clk);
         if (i == 9)  chk(key_ready == 1'b0, "R2 ready early", 256'(key_ready), 256'd0);
         if (i == 10) chk(key_ready == 1'b1, "R2 ready late", 256'(key_ready), 256'd1);
      end
   endtask

   task automatic run_op(input logic [255:0] d, input bit dec, output logic [255:0] res);
      logic [255:0] held;
      @(negedge clk);
      start   = 1'b1;
      data_in = d;
      decrypt = dec;
      @(negedge clk);
      start = 1'b0;
      for (int i = 1; i <= 10; i++) begin
         @(negedge clk);
         if (i == 9)  chk(done == 1'b0, "R5 done early", 256'(done), 256'd0);
         if (i == 10) chk(done == 1'b1, "R5 done missing", 256'(done), 256'd1);
      end
      res  = data_out;
      held = data_out;
      @(negedge clk);
      chk(done == 1'b0, "R5 done wider than one cycle", 256'(done), 256'd0);
      chk(data_out == held, "R5 data_out not held", data_out, held);
   endtask

   // ---------------- main sequence ----------------
   initial begin
      logic [255:0] ct, pt, res, exp;
      logic [127:0] kold;
      bit           seen;
      m_build_sbox();
      repeat (3) @(negedge clk);
      chk(done == 1'b0 && key_ready == 1'b0 && data_out == '0, "R1 during reset",
          data_out, 256'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(done == 1'b0 && key_ready == 1'b0 && data_out == '0, "R1 after reset",
          {data_out[253:0], done, key_ready}, 256'd0);

      // table of vectors
      for (int v = 0; v < NVEC; v++) begin
         pt = VEC[v][255:0];
         m_expand(VEC[v][383:256]);
         load_key(VEC[v][383:256]);
         exp = m_crypt(pt, 1'b0);
         run_op(pt, 1'b0, ct);
         chk(ct == exp, "R3 ciphertext", ct, exp);
         run_op(ct, 1'b1, res);
         chk(res == pt, "R4 round trip", res, pt);
         chk(m_crypt(ct, 1'b1) == pt, "R4 model round trip", m_crypt(ct, 1'b1), pt);
      end

      // R9: single-bit flips
      pt = VEC[3][255:0];
      run_op(pt, 1'b0, ct);
      run_op(pt ^ 256'd1, 1'b0, res);
      chk(res != ct, "R9 lsb flip", res, ct);
      chk(res == m_crypt(pt ^ 256'd1, 1'b0), "R3 flipped block", res, m_crypt(pt ^ 256'd1, 1'b0));
      run_op(pt ^ {1'b1, 255'd0}, 1'b0, res);
      chk(res != ct, "R9 msb flip", res, ct);

      // R6: start during a running operation
      pt  = VEC[1][255:0];
      exp = m_crypt(pt, 1'b0);
      @(negedge clk);
      start = 1'b1; data_in = pt; decrypt = 1'b0;
      @(negedge clk);
      start = 1'b0;
      seen = 1'b0;
      for (int i = 1; i <= 10; i++) begin
         @(negedge clk);
         if (i == 2) begin start = 1'b1; data_in = ~pt; decrypt = 1'b1; end
         if (i == 3) start = 1'b0;
         if (i < 10 && done) seen = 1'b1;
      end
      chk(done == 1'b1 && !seen, "R6 busy start changed timing", 256'(done), 256'd1);
      chk(data_out == exp, "R6 busy start changed result", data_out, exp);
      seen = 1'b0;
      for (int i = 0; i < 14; i++) begin
         @(negedge clk);
         if (done) seen = 1'b1;
      end
      chk(!seen, "R6 extra done after ignored start", 256'(seen), 256'd0);

      // R7: start with key load, then start before keys are ready
      @(negedge clk);
      key_valid = 1'b1; key_in = VEC[1][383:256]; start = 1'b1; data_in = pt; decrypt = 1'b0;
      @(negedge clk);
      key_valid = 1'b0;
      @(negedge clk);
      start = 1'b0;
      seen = 1'b0;
      for (int i = 0; i < 14; i++) begin
         @(negedge clk);
         if (done) seen = 1'b1;
      end
      chk(!seen, "R7 start accepted without ready keys", 256'(seen), 256'd0);
      chk(key_ready == 1'b1, "R2 ready after reload", 256'(key_ready), 256'd1);
      m_expand(VEC[1][383:256]);
      kold = VEC[1][383:256];

      // R8: key load during an operation
      exp = m_crypt(pt, 1'b0);
      @(negedge clk);
      start = 1'b1; data_in = pt; decrypt = 1'b0;
      @(negedge clk);
      start = 1'b0;
      for (int i = 1; i <= 10; i++) begin
         @(negedge clk);
         if (i == 2) begin key_valid = 1'b1; key_in = ~kold; end
         if (i == 3) key_valid = 1'b0;
      end
      chk(done == 1'b1 && data_out == exp, "R8 result with busy key load", data_out, exp);
      chk(key_ready == 1'b1, "R8 key_ready dropped", 256'(key_ready), 256'd1);
      run_op(pt ^ 256'hff, 1'b0, res);
      exp = m_crypt(pt ^ 256'hff, 1'b0);
      chk(res == exp, "R8 later operation uses old keys", res, exp);

      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      nchk++;
      nfail++;
      $display("FAIL R5 watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end
endmodule